// File: doc/BRIEF.md
# Paged 24-bit Address Generator

This block builds 24-bit memory addresses out of 16-bit register values and 8-bit page registers. On the data side, each of several data address units holds a 16-bit index and an 8-bit page. The selected unit presents the concatenation of its page and its index as the data address. A page never changes by itself: when software steps an index across a 64K boundary, the address stays in the old page until the page register is written.

On the fetch side, a 2-bit mode picks where the next instruction address comes from. It can be the next sequential word, a target relative to the program counter, a full 24-bit immediate carried by a two-word instruction, or an indirect target. The indirect target takes its low half from a 16-bit register value and its high byte from a dedicated indirect-branch page register. Sequential, relative and direct targets cover the whole 24-bit space linearly and never consult any page register.

All register writes are synchronous and take effect at the next clock edge. Both address outputs are combinational from the stored registers and the current inputs.

Top module: `paged_addr_gen`

## Requirements
- R1: After a write to a unit's index register, the data address for that unit carries the written value on bits [15:0] from the next cycle on.
- R2: After a write to a unit's page register, the data address for that unit carries the written value on bits [23:16] from the next cycle on, and the other units' addresses are unchanged.
- R3: A page register keeps its value whenever it is not written, including when its index is rewritten across a page boundary; the page is never inferred from the index.
- R4: After reset, every index and page register and the indirect-branch page register read as zero.
- R5: With mode 0 (sequential), the fetch address is PC+1 modulo 2^24, so 0xFFFFFF wraps to 0x000000.
- R6: With mode 1 (relative), the fetch address is PC plus the 16-bit offset sign-extended to 24 bits, modulo 2^24.
- R7: With mode 2 (direct), the fetch address equals the 24-bit immediate unchanged.
- R8: With mode 3 (indirect), the fetch address is the indirect-branch page on bits [23:16] and the 16-bit indirect source on bits [15:0].
- R9: A write to the indirect-branch page register becomes visible on the fetch address only in the cycle after the write; without a write the register holds.
- R10: Sequential, relative and direct fetch addresses do not depend on any page register: writes to data pages or to the indirect-branch page leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_we | input | NUM_DAG | Per-unit index write enable |
| idx_wdata | input | 16 | Index write data |
| pg_we | input | NUM_DAG | Per-unit data page write enable |
| pg_wdata | input | 8 | Data page write data |
| dag_sel | input | SEL_W | Unit whose address drives data_addr |
| ijp_we | input | 1 | Indirect-branch page write enable |
| ijp_wdata | input | 8 | Indirect-branch page write data |
| fmode | input | 2 | Fetch mode: 0 sequential, 1 relative, 2 direct, 3 indirect |
| pc | input | 24 | Current program counter |
| rel_ofs | input | 16 | Signed relative branch offset |
| dir_imm | input | 24 | Direct branch immediate |
| ind_src | input | 16 | Register value for indirect branches |
| data_addr | output | 24 | Data address of the selected unit |
| fetch_addr | output | 24 | Next fetch address |

## Verification
Both outputs are combinational, so a fetch result is due in the same cycle its inputs are driven. A register write is due one clock edge after its enable is driven. The bench drives inputs on the falling edge. For a write it holds the enable across exactly one rising edge and only then queues the read-back. The monitor compares each queued item one nanosecond after the falling edge on which it was queued. To check the write latency of R9, one check drives a write together with an indirect fetch and expects the old page in that cycle.

// File: rtl/paged_addr_pkg.sv
package paged_addr_pkg;
  localparam int IDX_W  = 16;
  localparam int PAGE_W = 8;
  localparam int ADDR_W = IDX_W + PAGE_W;
  localparam int OFS_W  = 16;

  typedef enum logic [1:0] {
    FM_SEQ = 2'd0,
    FM_REL = 2'd1,
    FM_DIR = 2'd2,
    FM_IND = 2'd3
  } fetch_mode_e;

  function automatic logic [ADDR_W-1:0] seq_target(input logic [ADDR_W-1:0] cur);
    return cur + ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] rel_target(input logic [ADDR_W-1:0] cur,
                                                   input logic [OFS_W-1:0]  ofs);
    logic [ADDR_W-1:0] ext;
    ext = {{(ADDR_W-OFS_W){ofs[OFS_W-1]}}, ofs};
    return cur + ext;
  endfunction

  function automatic logic [ADDR_W-1:0] paged(input logic [PAGE_W-1:0] pg,
                                              input logic [IDX_W-1:0]  low);
    return {pg, low};
  endfunction
endpackage

// File: rtl/pg_reg.sv
module pg_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end

  a_r9_hold_unwritten: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> q == $past(d));
endmodule

// File: rtl/dag_unit.sv
module dag_unit
  import paged_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_we,
  input  logic [IDX_W-1:0]  idx_wdata,
  input  logic              pg_we,
  input  logic [PAGE_W-1:0] pg_wdata,
  output logic [ADDR_W-1:0] addr
);
  logic [IDX_W-1:0]  idx_q;
  logic [PAGE_W-1:0] page_q;

  pg_reg #(.W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .we(idx_we), .d(idx_wdata), .q(idx_q)
  );
  pg_reg #(.W(PAGE_W)) u_page (
    .clk(clk), .rst_n(rst_n), .we(pg_we), .d(pg_wdata), .q(page_q)
  );

  assign addr = paged(page_q, idx_q);

  // index rewrite alone must never move the page
  logic idx_only_wr;
  assign idx_only_wr = idx_we && !pg_we;

  a_r3_page_not_inferred: assert property (@(posedge clk) disable iff (!rst_n)
    idx_only_wr |=> addr[ADDR_W-1:IDX_W] == $past(addr[ADDR_W-1:IDX_W]));
  a_r1_index_low_half: assert property (@(posedge clk) disable iff (!rst_n)
    idx_we |=> addr[IDX_W-1:0] == $past(idx_wdata));
endmodule

// File: rtl/fetch_sel.sv
module fetch_sel
  import paged_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ijp_we,
  input  logic [PAGE_W-1:0] ijp_wdata,
  input  fetch_mode_e       mode,
  input  logic [ADDR_W-1:0] pc,
  input  logic [OFS_W-1:0]  rel_ofs,
  input  logic [ADDR_W-1:0] dir_imm,
  input  logic [IDX_W-1:0]  ind_src,
  output logic [ADDR_W-1:0] fetch_addr
);
  logic [PAGE_W-1:0] ijp_q;
  logic              seq_wrap;
  logic              is_ind;

  pg_reg #(.W(PAGE_W)) u_ijp (
    .clk(clk), .rst_n(rst_n), .we(ijp_we), .d(ijp_wdata), .q(ijp_q)
  );

  always_comb begin
    unique case (mode)
      FM_SEQ:  fetch_addr = seq_target(pc);
      FM_REL:  fetch_addr = rel_target(pc, rel_ofs);
      FM_DIR:  fetch_addr = dir_imm;
      default: fetch_addr = paged(ijp_q, ind_src);
    endcase
  end

  assign seq_wrap = (mode == FM_SEQ) && (&pc);
  assign is_ind   = (mode == FM_IND);

  a_r5_seq_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    seq_wrap |-> fetch_addr == '0);
  a_r7_direct_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FM_DIR) |-> fetch_addr == dir_imm);
  a_r8_ind_page: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ind && ijp_we) |=> (!is_ind || fetch_addr[ADDR_W-1:IDX_W] == $past(ijp_wdata)));
endmodule

// File: rtl/paged_addr_gen.sv
module paged_addr_gen
  import paged_addr_pkg::*;
#(
  parameter int NUM_DAG = 2,
  localparam int SEL_W  = (NUM_DAG > 1) ? $clog2(NUM_DAG) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DAG-1:0] idx_we,
  input  logic [IDX_W-1:0]   idx_wdata,
  input  logic [NUM_DAG-1:0] pg_we,
  input  logic [PAGE_W-1:0]  pg_wdata,
  input  logic [SEL_W-1:0]   dag_sel,
  input  logic               ijp_we,
  input  logic [PAGE_W-1:0]  ijp_wdata,
  input  logic [1:0]         fmode,
  input  logic [ADDR_W-1:0]  pc,
  input  logic [OFS_W-1:0]   rel_ofs,
  input  logic [ADDR_W-1:0]  dir_imm,
  input  logic [IDX_W-1:0]   ind_src,
  output logic [ADDR_W-1:0]  data_addr,
  output logic [ADDR_W-1:0]  fetch_addr
);
  logic [ADDR_W-1:0] unit_addr [NUM_DAG];

  for (genvar g = 0; g < NUM_DAG; g++) begin : g_dag
    dag_unit u_dag (
      .clk(clk), .rst_n(rst_n),
      .idx_we(idx_we[g]), .idx_wdata(idx_wdata),
      .pg_we(pg_we[g]), .pg_wdata(pg_wdata),
      .addr(unit_addr[g])
    );
  end

  always_comb begin
    data_addr = '0;
    for (int k = 0; k < NUM_DAG; k++)
      if (dag_sel == SEL_W'(k)) data_addr = unit_addr[k];
  end

  fetch_sel u_fetch (
    .clk(clk), .rst_n(rst_n),
    .ijp_we(ijp_we), .ijp_wdata(ijp_wdata),
    .mode(fetch_mode_e'(fmode)),
    .pc(pc), .rel_ofs(rel_ofs), .dir_imm(dir_imm), .ind_src(ind_src),
    .fetch_addr(fetch_addr)
  );

  // non-indirect fetch must not move while its own inputs hold, whatever pages do
  logic nonpaged_mode;
  assign nonpaged_mode = (fmode != 2'd3);

  a_r10_no_page_in_linear: assert property (@(posedge clk) disable iff (!rst_n)
    (nonpaged_mode && $stable(fmode) && $stable(pc) && $stable(rel_ofs) && $stable(dir_imm))
      |-> $stable(fetch_addr));
endmodule

// File: tb/test_paged_addr_gen.sv
module test_paged_addr_gen;
  localparam int ND = 2;

  typedef struct {
    int          req;
    bit          is_fetch;
    logic [23:0] exp;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [ND-1:0] idx_we = '0, pg_we = '0;
  logic [15:0] idx_wdata = '0;
  logic [7:0]  pg_wdata = '0;
  logic [0:0]  dag_sel = '0;
  logic        ijp_we = 1'b0;
  logic [7:0]  ijp_wdata = '0;
  logic [1:0]  fmode = '0;
  logic [23:0] pc = '0, dir_imm = '0;
  logic [15:0] rel_ofs = '0, ind_src = '0;
  logic [23:0] data_addr, fetch_addr;

  int n_chk = 0, n_fail = 0, cycles = 0;
  item_t sb[$];

  always #2.5 clk = ~clk;

  paged_addr_gen #(.NUM_DAG(ND)) i_paged_addr_gen (
    .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .idx_wdata(idx_wdata),
    .pg_we(pg_we), .pg_wdata(pg_wdata), .dag_sel(dag_sel),
    .ijp_we(ijp_we), .ijp_wdata(ijp_wdata), .fmode(fmode), .pc(pc),
    .rel_ofs(rel_ofs), .dir_imm(dir_imm), .ind_src(ind_src),
    .data_addr(data_addr), .fetch_addr(fetch_addr)
  );

  function automatic logic [23:0] ref_rel(logic [23:0] p, logic [15:0] o);
    int s;
    s = int'(p) + int'($signed(o));
    return s[23:0];
  endfunction

  // monitor: pops what the driver queued on this falling edge
  always begin
    @(negedge clk);
    #1;
    while (sb.size() > 0) begin
      item_t it;
      logic [23:0] act;
      it = sb.pop_front();
      act = it.is_fetch ? fetch_addr : data_addr;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL R%0d: %s actual=%06h expected=%06h", it.req,
                 it.is_fetch ? "fetch" : "data", act, it.exp);
      end
    end
  end

  task automatic wr_idx(int k, logic [15:0] v);
    idx_we[k] = 1'b1; idx_wdata = v; @(negedge clk); idx_we = '0;
  endtask
  task automatic wr_pg(int k, logic [7:0] v);
    pg_we[k] = 1'b1; pg_wdata = v; @(negedge clk); pg_we = '0;
  endtask
  task automatic exp_data(int req, int k, logic [23:0] e);
    dag_sel = 1'(k);
    sb.push_back('{req, 1'b0, e}); @(negedge clk);
  endtask
  task automatic exp_fetch(int req, logic [1:0] m, logic [23:0] e);
    fmode = m;
    sb.push_back('{req, 1'b1, e}); @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 reset state
    exp_data(4, 0, 24'h0);
    exp_data(4, 1, 24'h0);
    ind_src = 16'h1234;
    exp_fetch(4, 2'd3, 24'h001234);
    // R1, R2 load and combine
    wr_idx(0, 16'hFFFF);
    wr_pg(0, 8'h12);
    exp_data(1, 0, 24'h12FFFF);
    exp_data(2, 1, 24'h000000);
    // R3 crossing boundary needs explicit page write
    wr_idx(0, 16'h0000);
    exp_data(3, 0, 24'h120000);
    wr_pg(1, 8'hAB);
    wr_idx(1, 16'h5555);
    exp_data(2, 1, 24'hAB5555);
    exp_data(3, 0, 24'h120000);
    // R5 sequential
    pc = 24'h00ABCD; exp_fetch(5, 2'd0, 24'h00ABCE);
    pc = 24'hFFFFFF; exp_fetch(5, 2'd0, 24'h000000);
    // R6 relative
    pc = 24'h010000; rel_ofs = 16'hFFFF; exp_fetch(6, 2'd1, ref_rel(pc, rel_ofs));
    pc = 24'hFFFFF0; rel_ofs = 16'h0020; exp_fetch(6, 2'd1, ref_rel(pc, rel_ofs));
    pc = 24'h000000; rel_ofs = 16'h8000; exp_fetch(6, 2'd1, 24'hFF8000);
    // R7 direct
    dir_imm = 24'hC0FFEE; exp_fetch(7, 2'd2, 24'hC0FFEE);
    // R10 data page write while direct/relative selected
    pg_we[0] = 1'b1; pg_wdata = 8'h99; fmode = 2'd2;
    sb.push_back('{10, 1'b1, 24'hC0FFEE}); @(negedge clk); pg_we = '0;
    exp_fetch(10, 2'd2, 24'hC0FFEE);
    // R9 write cycle still shows old page; next cycle new
    ind_src = 16'h4321; ijp_we = 1'b1; ijp_wdata = 8'h7E; fmode = 2'd3;
    sb.push_back('{9, 1'b1, 24'h004321}); @(negedge clk); ijp_we = 1'b0;
    exp_fetch(8, 2'd3, 24'h7E4321);
    ind_src = 16'hBEEF; exp_fetch(9, 2'd3, 24'h7EBEEF);
    // R10 indirect page does not leak into relative/sequential
    pc = 24'h000100; rel_ofs = 16'h0010; exp_fetch(10, 2'd1, 24'h000110);
    exp_fetch(10, 2'd0, 24'h000101);
    exp_data(2, 0, 24'h990000);
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule